// File: doc/BRIEF.md
# Torus Node Packet Router

This block switches packets at one node of a two-dimensional torus. Each node has one incoming and one outgoing unidirectional link per dimension plus a local injection/ejection port. Each of the three ports carries two virtual channels (VCs). Packets are wormhole-switched flit by flit. The head flit names the destination column and row. The router finishes all travel along the column dimension (X) before it moves a packet along the row dimension (Y). The path therefore depends only on the source and destination addresses.

Deadlock freedom comes from the VC choice. A packet enters a dimension on VC0. It moves to VC1 on the hop that crosses the wraparound link of that dimension, which is the link leaving the node with the highest coordinate. It goes back to VC0 when it turns into the next dimension. Flow control works by credits for each port and VC. Every input VC buffer returns one credit pulse for each flit it frees. Every output VC holds a counter of free slots in the neighbour's buffer. When several input VCs compete for one output link, a round-robin arbiter chooses among them. An output VC stays locked to one packet from its head flit to its tail flit.

Top module: `torus_router`

## Requirements
- R1: While `rst` is high and in the cycles after it, with no input traffic, `out_valid` and `in_credit` are all zero. Each output VC starts with DEPTH credits.
- R2: Port index 0 is local, 1 is X and 2 is Y. In a flit, bit FW-1 marks the head and bit FW-2 marks the tail. The next XW bits below them hold the destination x, and the YW bits below those hold the destination y. A head whose destination x differs from `my_x` leaves on port 1. Otherwise, if its destination y differs from `my_y`, it leaves on port 2. Otherwise it leaves on port 0.
- R3: A packet that arrives on the port of the dimension it leaves in keeps its incoming VC. A packet that enters a dimension from another port starts on VC0. In both cases a hop leaving on X from `my_x`=XN-1, or on Y from `my_y`=YN-1, uses VC1. Ejection to the local port always uses VC0.
- R4: All flits of a packet leave in order on one port and VC, starting with the head and ending with the tail. No flit of another packet appears on that port and VC in between.
- R5: An output VC never holds more unreturned flits than DEPTH. With no credits returned, exactly DEPTH flits leave on it and then it stalls.
- R6: Each flit removed from an input VC buffer produces exactly one one-cycle pulse on `in_credit` for that port and VC. After traffic drains, the upstream side has recovered all DEPTH credits for each VC.
- R7: When two input VCs continuously compete for the same output VC with single-flit packets, grants alternate between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_x | input | XW | Column coordinate of this node |
| my_y | input | YW | Row coordinate of this node |
| in_valid | input | 3 | Flit present on each input port |
| in_vc | input | 3 | VC of the incoming flit on each port |
| in_flit | input | 3 x FW | Incoming flit on each port |
| in_credit | output | 3 x 2 | Credit pulse to the upstream neighbour per port and VC |
| out_valid | output | 3 | Flit present on each output port (registered) |
| out_vc | output | 3 | VC of the outgoing flit on each port |
| out_flit | output | 3 x FW | Outgoing flit on each port |
| out_credit | input | 3 x 2 | Credit pulse from the downstream neighbour per port and VC |

## Verification
The hardest situations to reach from the ports are two. One is a packet that is partway out of a locked output VC while another head waits for that same VC. The other is an output VC that runs dry of credits while its input buffer fills behind it. Random traffic reaches both. It injects multi-flit packets on all three ports at once, including packets that turn from X into Y. It returns downstream credits only intermittently, so locks overlap and VCs stall mid-packet. Directed phases cover the rest. One withholds credits on one output VC to expose the exact DEPTH limit. Another feeds two inputs at full rate into the same output VC to expose the arbitration order. Random traffic also runs at corner coordinates, so that both wraparound rules are exercised.

// File: rtl/torus_pkg.sv
package torus_pkg;
  localparam int NP = 3;             // ports: local, X, Y
  localparam int NV = 2;             // virtual channels per link
  localparam int NCH = NP * NV;      // input channels
  localparam logic [1:0] PORT_L = 2'd0;
  localparam logic [1:0] PORT_X = 2'd1;
  localparam logic [1:0] PORT_Y = 2'd2;

  typedef struct packed {
    logic [1:0] port;
    logic       vc;
  } route_t;
endpackage

// File: rtl/torus_in_fifo.sv
module torus_in_fifo #(
  parameter int FW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [FW-1:0] din,
  input  logic          pop,
  output logic [FW-1:0] dout,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [FW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (!push && pop) cnt <= cnt - 1'b1;
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt != CW'(DEPTH))); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R4
endmodule

// File: rtl/torus_route.sv
module torus_route
  import torus_pkg::*;
#(
  parameter int XN      = 4,
  parameter int YN      = 4,
  parameter int IN_PORT = 0,
  localparam int XW = $clog2(XN),
  localparam int YW = $clog2(YN)
) (
  input  logic [XW-1:0] my_x,
  input  logic [YW-1:0] my_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  input  logic          in_vc,
  output route_t        rt
);
  always_comb begin
    if (dst_x != my_x) begin
      rt.port = PORT_X;
      rt.vc   = ((IN_PORT == int'(PORT_X)) ? in_vc : 1'b0) | (my_x == XW'(XN - 1));
    end else if (dst_y != my_y) begin
      rt.port = PORT_Y;
      rt.vc   = ((IN_PORT == int'(PORT_Y)) ? in_vc : 1'b0) | (my_y == YW'(YN - 1));
    end else begin
      rt.port = PORT_L;
      rt.vc   = 1'b0;
    end
  end
endmodule

// File: rtl/torus_rr_arb.sv
module torus_rr_arb #(
  parameter int N = 6,
  localparam int PW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [PW-1:0] ptr;
  int            win;

  always_comb begin
    grant = '0;
    win   = 0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[(int'(ptr) + k) % N]) win = (int'(ptr) + k) % N;
    end
    if (|req) grant[win] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (|req) ptr <= PW'((win + 1) % N);
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R7
  AST_GRANT_WHEN_REQ: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> (|grant)); // R7
endmodule

// File: rtl/torus_router.sv
module torus_router
  import torus_pkg::*;
#(
  parameter int XN    = 4,
  parameter int YN    = 4,
  parameter int FW    = 32,
  parameter int DEPTH = 4,
  localparam int XW = $clog2(XN),
  localparam int YW = $clog2(YN)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [XW-1:0]          my_x,
  input  logic [YW-1:0]          my_y,
  input  logic [NP-1:0]          in_valid,
  input  logic [NP-1:0]          in_vc,
  input  logic [NP-1:0][FW-1:0]  in_flit,
  output logic [NP-1:0][NV-1:0]  in_credit,
  output logic [NP-1:0]          out_valid,
  output logic [NP-1:0]          out_vc,
  output logic [NP-1:0][FW-1:0]  out_flit,
  input  logic [NP-1:0][NV-1:0]  out_credit
);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int HEAD  = FW - 1;
  localparam int TAIL  = FW - 2;
  localparam int XTOP  = FW - 3;
  localparam int YTOP  = FW - 3 - XW;

  logic [FW-1:0]  dout    [NCH];
  logic [NCH-1:0] empty, pop, is_head;
  route_t         rcomp   [NCH];
  route_t         rstore  [NCH];
  route_t         tgt     [NCH];
  logic [NCH-1:0] req     [NP];
  logic [NCH-1:0] grant   [NP];
  logic [FW-1:0]  sel_flit[NP];
  logic           sel_vc  [NP];
  logic           send    [NP][NV];
  logic [CW-1:0]  credit  [NP][NV];
  logic           owned   [NP][NV];

  // input channels: buffer + route computation
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int P = c / NV;
    localparam int V = c % NV;

    torus_in_fifo #(.FW(FW), .DEPTH(DEPTH)) u_fifo (
      .clk  (clk),
      .rst  (rst),
      .push (in_valid[P] && (in_vc[P] == 1'(V))),
      .din  (in_flit[P]),
      .pop  (pop[c]),
      .dout (dout[c]),
      .empty(empty[c])
    );

    torus_route #(.XN(XN), .YN(YN), .IN_PORT(P)) u_route (
      .my_x (my_x),
      .my_y (my_y),
      .dst_x(dout[c][XTOP -: XW]),
      .dst_y(dout[c][YTOP -: YW]),
      .in_vc(1'(V)),
      .rt   (rcomp[c])
    );

    assign is_head[c] = dout[c][HEAD];
    assign tgt[c]     = is_head[c] ? rcomp[c] : rstore[c];

    always_ff @(posedge clk) begin
      if (rst)                       rstore[c] <= '0;
      else if (pop[c] && is_head[c]) rstore[c] <= rcomp[c];
    end
  end

  // requests: a head needs a free output VC, every flit needs a credit
  always_comb begin
    for (int q = 0; q < NP; q++) begin
      for (int c = 0; c < NCH; c++) begin
        req[q][c] = !empty[c] && (tgt[c].port == 2'(q)) &&
                    (credit[q][tgt[c].vc] != '0) &&
                    (!is_head[c] || !owned[q][tgt[c].vc]);
      end
    end
  end

  // one arbiter per physical output link
  for (genvar q = 0; q < NP; q++) begin : g_out
    torus_rr_arb #(.N(NCH)) u_arb (
      .clk  (clk),
      .rst  (rst),
      .req  (req[q]),
      .grant(grant[q])
    );
  end

  always_comb begin
    pop = '0;
    for (int q = 0; q < NP; q++) begin
      sel_flit[q] = '0;
      sel_vc[q]   = 1'b0;
      for (int c = 0; c < NCH; c++) begin
        if (grant[q][c]) begin
          sel_flit[q] = sel_flit[q] | dout[c];
          sel_vc[q]   = sel_vc[q] | tgt[c].vc;
          pop[c]      = 1'b1;
        end
      end
      for (int v = 0; v < NV; v++) send[q][v] = (|grant[q]) && (sel_vc[q] == 1'(v));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      out_vc    <= '0;
      out_flit  <= '0;
      in_credit <= '0;
      for (int q = 0; q < NP; q++) begin
        for (int v = 0; v < NV; v++) begin
          credit[q][v] <= CW'(DEPTH);
          owned[q][v]  <= 1'b0;
        end
      end
    end else begin
      for (int q = 0; q < NP; q++) begin
        out_valid[q] <= |grant[q];
        out_vc[q]    <= sel_vc[q];
        out_flit[q]  <= sel_flit[q];
        for (int v = 0; v < NV; v++) begin
          in_credit[q][v] <= pop[q*NV + v];
          case ({out_credit[q][v], send[q][v]})
            2'b10:   credit[q][v] <= credit[q][v] + 1'b1;
            2'b01:   credit[q][v] <= credit[q][v] - 1'b1;
            default: credit[q][v] <= credit[q][v];
          endcase
          if (send[q][v]) begin
            if (sel_flit[q][TAIL])      owned[q][v] <= 1'b0;
            else if (sel_flit[q][HEAD]) owned[q][v] <= 1'b1;
          end
        end
      end
    end
  end

  for (genvar q = 0; q < NP; q++) begin : g_chk
    for (genvar v = 0; v < NV; v++) begin : g_vc
      AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        credit[q][v] <= CW'(DEPTH)); // R5
    end
  end

  AST_EJECT_ADDR: assert property (@(posedge clk) disable iff (rst)
    (out_valid[PORT_L] && out_flit[PORT_L][HEAD]) |->
      (out_flit[PORT_L][XTOP -: XW] == my_x && out_flit[PORT_L][YTOP -: YW] == my_y)); // R2
  AST_X_BEFORE_Y: assert property (@(posedge clk) disable iff (rst)
    (out_valid[PORT_Y] && out_flit[PORT_Y][HEAD]) |->
      (out_flit[PORT_Y][XTOP -: XW] == my_x)); // R2
  AST_DATELINE_X: assert property (@(posedge clk) disable iff (rst)
    (out_valid[PORT_X] && my_x == XW'(XN - 1)) |-> out_vc[PORT_X]); // R3
  AST_LOCAL_VC0: assert property (@(posedge clk) disable iff (rst)
    out_valid[PORT_L] |-> !out_vc[PORT_L]); // R3
endmodule

// File: tb/tb_torus_router.sv
`timescale 1ns/1ps
module tb_torus_router;
  localparam int XN = 4, YN = 4, FW = 32, DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] my_x = '0, my_y = '0;
  logic [2:0] in_valid = '0, in_vc = '0;
  logic [2:0][31:0] in_flit = '0;
  logic [2:0][1:0]  in_credit;
  logic [2:0]       out_valid, out_vc;
  logic [2:0][31:0] out_flit;
  logic [2:0][1:0]  out_credit = '0;

  always #2.5 clk = ~clk;

  torus_router #(.XN(XN), .YN(YN), .FW(FW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .my_x(my_x), .my_y(my_y),
    .in_valid(in_valid), .in_vc(in_vc), .in_flit(in_flit), .in_credit(in_credit),
    .out_valid(out_valid), .out_vc(out_vc), .out_flit(out_flit), .out_credit(out_credit)
  );

  int checks = 0, fails = 0;
  int mx, my;
  int exp_port[256], exp_vc[256], exp_len[256], exp_src[256], src_vc[256], pdx[256], pdy[256];
  int npk, ndel, inj_pct;
  int qp[3][$];
  int iseq[3];
  int bc[3][2], outst[3][2], got[3][2], cur_id[3][2], cur_cnt[3][2];
  bit busy[3][2], hold[3][2];
  bit rr_on;
  int rr_log[$];

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // expected route from the requirements (R2, R3)
  task automatic model_route(int src, int vc, int dx, int dy, output int port, output int ovc);
    if (dx != mx) begin
      port = 1; ovc = ((src == 1) ? vc : 0) | ((mx == XN - 1) ? 1 : 0);
    end else if (dy != my) begin
      port = 2; ovc = ((src == 2) ? vc : 0) | ((my == YN - 1) ? 1 : 0);
    end else begin
      port = 0; ovc = 0;
    end
  endtask

  task automatic add_pkt(int src, int vc, int dx, int dy, int len);
    int id, p, v;
    id = npk; npk++;
    model_route(src, vc, dx, dy, p, v);
    exp_port[id] = p; exp_vc[id] = v; exp_len[id] = len;
    exp_src[id] = src; src_vc[id] = vc; pdx[id] = dx; pdy[id] = dy;
    qp[src].push_back(id);
  endtask

  function automatic logic [31:0] mk(int id, int sq);
    return {(sq == 0), (sq == exp_len[id] - 1), 2'(pdx[id]), 2'(pdy[id]), 10'd0, 8'(id), 8'(sq)};
  endfunction

  // one bench cycle at the falling edge: observe, return credits, drive
  task automatic step();
    @(negedge clk);
    for (int q = 0; q < 3; q++) begin
      if (out_valid[q]) begin
        int v, id, sq;
        logic [31:0] f;
        v = int'(out_vc[q]); f = out_flit[q]; id = int'(f[15:8]); sq = int'(f[7:0]);
        got[q][v]++; outst[q][v]++;
        chk(outst[q][v] <= DEPTH, "R5", "unreturned flits on output VC", outst[q][v], DEPTH);
        if (f[31]) begin
          chk(!busy[q][v], "R4", "head inside an open packet", 1, 0);
          chk(q == exp_port[id], "R2", "output port", q, exp_port[id]);
          chk(v == exp_vc[id], "R3", "output VC", v, exp_vc[id]);
          chk(sq == 0, "R4", "head sequence", sq, 0);
          busy[q][v] = 1; cur_id[q][v] = id; cur_cnt[q][v] = 0;
          if (rr_on && q == 1 && v == 0) rr_log.push_back(exp_src[id]);
        end else begin
          chk(busy[q][v] && id == cur_id[q][v], "R4", "body flit packet id", id, cur_id[q][v]);
          chk(sq == cur_cnt[q][v], "R4", "flit order", sq, cur_cnt[q][v]);
        end
        cur_cnt[q][v]++;
        if (f[30]) begin
          chk(cur_cnt[q][v] == exp_len[cur_id[q][v]], "R4", "packet length", cur_cnt[q][v], exp_len[cur_id[q][v]]);
          busy[q][v] = 0; ndel++;
        end
      end
    end
    for (int p = 0; p < 3; p++) begin
      for (int v = 0; v < 2; v++) begin
        if (in_credit[p][v]) begin
          bc[p][v]++;
          chk(bc[p][v] <= DEPTH, "R6", "upstream credits", bc[p][v], DEPTH);
        end
        out_credit[p][v] = 1'b0;
        if (outst[p][v] > 0 && !hold[p][v] && ($urandom % 4 != 0)) begin
          out_credit[p][v] = 1'b1; outst[p][v]--;
        end
      end
    end
    for (int p = 0; p < 3; p++) begin
      in_valid[p] = 1'b0;
      if (qp[p].size() > 0 && int'($urandom % 100) < inj_pct) begin
        int id, v;
        id = qp[p][0]; v = src_vc[id];
        if (bc[p][v] > 0) begin
          in_valid[p] = 1'b1; in_vc[p] = 1'(v); in_flit[p] = mk(id, iseq[p]);
          bc[p][v]--; iseq[p]++;
          if (iseq[p] == exp_len[id]) begin
            void'(qp[p].pop_front()); iseq[p] = 0;
          end
        end
      end
    end
  endtask

  task automatic do_reset(int x, int y);
    @(negedge clk);
    rst = 1'b1; mx = x; my = y; my_x = 2'(x); my_y = 2'(y);
    in_valid = '0; out_credit = '0;
    npk = 0; ndel = 0; rr_on = 0; rr_log.delete();
    for (int p = 0; p < 3; p++) begin
      qp[p].delete(); iseq[p] = 0;
      for (int v = 0; v < 2; v++) begin
        bc[p][v] = DEPTH; outst[p][v] = 0; got[p][v] = 0; busy[p][v] = 0; hold[p][v] = 0;
      end
    end
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R1", "out_valid during reset", int'(out_valid), 0);
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
      chk(in_credit == '0, "R1", "in_credit after reset", int'(in_credit), 0);
    end
  endtask

  task automatic drain();
    bit done;
    done = 0;
    for (int i = 0; i < 3000 && !done; i++) begin
      step();
      done = (ndel == npk);
      for (int p = 0; p < 3; p++)
        for (int v = 0; v < 2; v++)
          if (outst[p][v] != 0 || bc[p][v] != DEPTH) done = 0;
    end
    chk(ndel == npk, "R4", "packets delivered", ndel, npk);
    for (int p = 0; p < 3; p++)
      for (int v = 0; v < 2; v++)
        chk(bc[p][v] == DEPTH, "R6", "credits recovered", bc[p][v], DEPTH);
  endtask

  task automatic random_phase(int x, int y, int n);
    do_reset(x, y);
    inj_pct = 75;
    for (int i = 0; i < n; i++) begin
      int src;
      src = int'($urandom % 3);
      add_pkt(src, (src == 0) ? 0 : int'($urandom % 2), int'($urandom % XN), int'($urandom % YN),
              1 + int'($urandom % 4));
    end
    drain();
  endtask

  initial begin
    void'($urandom(32'h5eed_7a11));
    // R1: reset state
    do_reset(1, 1);

    // R5/R1: credits held on X VC0, exactly DEPTH flits leave
    hold[1][0] = 1; inj_pct = 100;
    add_pkt(0, 0, 2, 1, DEPTH + 3);
    repeat (40) step();
    chk(got[1][0] == DEPTH, "R5", "flits sent with no credit return", got[1][0], DEPTH);
    hold[1][0] = 0;
    drain();

    // R7: local and X VC0 both feed X VC0 with single-flit packets
    do_reset(1, 1);
    inj_pct = 100; rr_on = 1;
    for (int i = 0; i < 8; i++) begin
      add_pkt(0, 0, 2, 0, 1);
      add_pkt(1, 0, 3, 2, 1);
    end
    drain();
    chk(rr_log.size() == 16, "R7", "contending packets seen", rr_log.size(), 16);
    for (int k = 1; k < rr_log.size(); k++)
      chk(rr_log[k] != rr_log[k-1], "R7", "source repeated while other waited", rr_log[k], 1 - rr_log[k-1]);

    // R3: turn from X VC1 into Y resets to VC0 away from the dateline
    do_reset(1, 2);
    inj_pct = 100;
    add_pkt(1, 1, 1, 0, 2);
    add_pkt(2, 1, 1, 0, 1);
    drain();

    // random traffic at interior and corner coordinates (R2-R6)
    random_phase(1, 2, 120);
    random_phase(3, 3, 120);
    random_phase(0, 3, 120);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule